// File: doc/BRIEF.md
# SD Host Command Launch and Response Capture

This block is the front end through which software issues commands on an SD host. Software first writes a 32-bit argument, then writes a 32-bit command word. An accepted command word is handed, together with the argument, to a separate command-line engine through a one-cycle start pulse. The engine later returns a done indication, the received response bits and its error flags. The block has no part in the serial framing, the CRC generation or the data transfer.

The command word is decoded at launch. The decode sets a command-busy inhibit flag. It also sets a data-busy inhibit flag when the command moves data or expects a response followed by busy signalling. When the engine finishes, the block captures the response into four 32-bit response words. A long response is stored without its trailing CRC byte. The block then signals completion or the cause of an error with single-cycle event pulses. Separate soft-reset inputs for the command path and the data path release the two inhibit flags. The transfer attributes of the launched command are held on outputs for the data path.

Top module: `sd_cmd_issue`

## Requirements
- R1: After rst_ni is asserted, both inhibit flags, eng_start_o, all event pulses and resp_o are 0.
- R2: A write to the command offset (word offset 3) while cmd_inhibit_o is 0 is accepted. In the next cycle eng_start_o is 1 for exactly one cycle, eng_cmd_o holds the written word, eng_arg_o holds the value last written to the argument offset (word offset 2), and cmd_inhibit_o is 1.
- R3: On an accepted command, dat_inhibit_o becomes 1 if the data-present bit 21 is set or the response kind in bits 17:16 equals 3 (short with busy). Otherwise dat_inhibit_o keeps its value.
- R4: A command write while cmd_inhibit_o is 1 is ignored: no start pulse is produced and eng_cmd_o and eng_arg_o keep their values, even if the argument is rewritten meanwhile.
- R5: eng_done_i while cmd_inhibit_o is 1 clears cmd_inhibit_o in the next cycle. In that same cycle exactly one of cmd_done_o or cmd_err_o pulses, for one cycle.
- R6: An error is reported in one of three cases. A timeout (eng_timeout_i) is reported first and masks the other checks. A CRC error is reported when eng_crc_bad_i is set and bit 19 enables CRC checking. An index error is reported when the response kind is 2 or 3, bit 20 enables index checking, and eng_resp_i[37:32] differs from the command index in bits 29:24. A flag whose check is disabled does not cause an error.
- R7: With response kind 1 (136-bit), resp_o becomes {8'h00, eng_resp_i[127:8]}.
- R8: With response kind 2 or 3, resp_o[31:0] becomes eng_resp_i[31:0] and resp_o[127:32] is kept. With kind 0, resp_o is kept.
- R9: On a timeout, resp_o keeps its previous contents.
- R10: cmd_srst_i clears cmd_inhibit_o in the next cycle and wins over a command write in the same cycle. An eng_done_i while cmd_inhibit_o is 0 produces no event and leaves resp_o unchanged.
- R11: dat_srst_i clears dat_inhibit_o in the next cycle and wins over a setting command in the same cycle.
- R12: xfer_multi_o, xfer_rd_o, blkcnt_en_o, auto_cmd_o and cmd_type_o equal bits 5, 4, 1, 3:2 and 23:22 of the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register word offset |
| wr_data_i | input | 32 | Register write data |
| cmd_srst_i | input | 1 | Command-path soft reset |
| dat_srst_i | input | 1 | Data-path soft reset |
| eng_start_o | output | 1 | Command start pulse to the engine |
| eng_cmd_o | output | 32 | Launched command word |
| eng_arg_o | output | 32 | Launched argument |
| eng_done_i | input | 1 | Engine finished the command |
| eng_resp_i | input | 128 | Received response bits |
| eng_timeout_i | input | 1 | Engine saw no response |
| eng_crc_bad_i | input | 1 | Engine found a response CRC mismatch |
| cmd_inhibit_o | output | 1 | Command path busy |
| dat_inhibit_o | output | 1 | Data path busy |
| resp_o | output | 128 | Four response words, word 0 in bits 31:0 |
| cmd_done_o | output | 1 | Successful completion pulse |
| cmd_err_o | output | 1 | Error completion pulse |
| err_timeout_o | output | 1 | Error cause: timeout |
| err_crc_o | output | 1 | Error cause: CRC |
| err_index_o | output | 1 | Error cause: index mismatch |
| xfer_multi_o | output | 1 | Launched command is multi-block |
| xfer_rd_o | output | 1 | Launched transfer is card to host |
| blkcnt_en_o | output | 1 | Block counter enabled |
| auto_cmd_o | output | 2 | Automatic stop/count command select |
| cmd_type_o | output | 2 | Command type (normal, suspend, resume, abort) |

## Verification
The command word is exercised with every response kind. A no-response command shows that the response words stay untouched. A long response shows that the CRC byte is dropped. Short responses show that only word 0 is overwritten, and a short response with busy shows that data-inhibit is raised without a data bit. Error flags are paired with their check enables both set and cleared, which separates a real CRC or index error from a flag that must be ignored. A timeout carries a response pattern that would be visible if it were stored. Directed sequences then check writes during a busy command, a late engine completion after a command soft reset, and a soft reset colliding with a write.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int WORD_W    = 32;
  localparam int RSP_W     = 128;
  localparam int NUM_WORDS = RSP_W / WORD_W;
  localparam int CRC_W     = 8;

  // command word bit positions
  localparam int IDX_LSB   = 24;
  localparam int IDX_W     = 6;
  localparam int TYPE_LSB  = 22;
  localparam int DATA_BIT  = 21;
  localparam int IXCHK_BIT = 20;
  localparam int CRCCHK_BIT= 19;
  localparam int RSP_LSB   = 16;
  localparam int MULTI_BIT = 5;
  localparam int DIR_BIT   = 4;
  localparam int AUTO_LSB  = 2;
  localparam int BCNT_BIT  = 1;

  // echoed index position in a short response
  localparam int RIDX_LSB  = 32;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_LONG  = 2'd1,
    RSP_SHORT = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic tmo;
    logic crc;
    logic idx;
  } err_cause_t;
endpackage

// File: rtl/sd_cmd_launch.sv
module sd_cmd_launch
  import sd_cmd_pkg::*;
#(
  parameter int AW      = 4,
  parameter int ARG_OFS = 2,
  parameter int CMD_OFS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              cmd_busy_i,
  input  logic              cmd_srst_i,
  output logic              launch_o,
  output logic              start_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic [WORD_W-1:0] arg_o
);
  localparam logic [AW-1:0] ARG_A = AW'(ARG_OFS);
  localparam logic [AW-1:0] CMD_A = AW'(CMD_OFS);

  logic [WORD_W-1:0] arg_shadow_q;
  logic              arg_wr;

  assign arg_wr   = wr_en_i && (wr_addr_i == ARG_A);
  assign launch_o = wr_en_i && (wr_addr_i == CMD_A) && !cmd_busy_i && !cmd_srst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_shadow_q <= '0;
    end else if (arg_wr) begin
      arg_shadow_q <= wr_data_i;
    end
  end

  // argument is frozen at launch so later writes do not disturb the engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_word_o <= '0;
      arg_o      <= '0;
      start_o    <= 1'b0;
    end else begin
      start_o <= launch_o;
      if (launch_o) begin
        cmd_word_o <= wr_data_i;
        arg_o      <= arg_shadow_q;
      end
    end
  end
endmodule

// File: rtl/sd_cmd_flags.sv
module sd_cmd_flags
  import sd_cmd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      launch_i,
  input  logic      has_data_i,
  input  rsp_kind_e rsp_i,
  input  logic      evt_i,
  input  logic      cmd_srst_i,
  input  logic      dat_srst_i,
  output logic      cmd_inhibit_o,
  output logic      dat_inhibit_o
);
  logic dat_set;

  assign dat_set = launch_i && (has_data_i || (rsp_i == RSP_BUSY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_inhibit_o <= 1'b0;
    end else if (cmd_srst_i) begin
      cmd_inhibit_o <= 1'b0;
    end else if (launch_i) begin
      cmd_inhibit_o <= 1'b1;
    end else if (evt_i) begin
      cmd_inhibit_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_inhibit_o <= 1'b0;
    end else if (dat_srst_i) begin
      dat_inhibit_o <= 1'b0;
    end else if (dat_set) begin
      dat_inhibit_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sd_cmd_resp.sv
module sd_cmd_resp
  import sd_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  rsp_kind_e        rsp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             idx_chk_i,
  input  logic             crc_chk_i,
  input  logic [RSP_W-1:0] eng_resp_i,
  input  logic             eng_timeout_i,
  input  logic             eng_crc_bad_i,
  output logic [RSP_W-1:0] resp_o,
  output logic             done_o,
  output logic             err_o,
  output err_cause_t       cause_o
);
  err_cause_t       cause;
  logic             any_err;
  logic             short_kind;
  logic             store_long;
  logic             store_short;
  logic [RSP_W-1:0] long_val;

  assign short_kind = rsp_i[1];
  assign long_val   = {{CRC_W{1'b0}}, eng_resp_i[RSP_W-1:CRC_W]};

  always_comb begin
    cause.tmo = eng_timeout_i;
    cause.crc = !eng_timeout_i && crc_chk_i && eng_crc_bad_i;
    cause.idx = !eng_timeout_i && short_kind && idx_chk_i &&
                (eng_resp_i[RIDX_LSB +: IDX_W] != idx_i);
  end

  assign any_err     = |cause;
  assign store_long  = evt_i && !eng_timeout_i && (rsp_i == RSP_LONG);
  assign store_short = evt_i && !eng_timeout_i && short_kind;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    if (g == 0) begin : g_low
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          word_q <= '0;
        else if (store_long)  word_q <= long_val[g*WORD_W +: WORD_W];
        else if (store_short) word_q <= eng_resp_i[WORD_W-1:0];
      end
    end else begin : g_high
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         word_q <= '0;
        else if (store_long) word_q <= long_val[g*WORD_W +: WORD_W];
      end
    end
    assign resp_o[g*WORD_W +: WORD_W] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      cause_o <= '0;
    end else begin
      done_o  <= evt_i && !any_err;
      err_o   <= evt_i && any_err;
      cause_o <= evt_i ? cause : '0;
    end
  end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int AW      = 4,
  parameter int ARG_OFS = 2,
  parameter int CMD_OFS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              cmd_srst_i,
  input  logic              dat_srst_i,
  output logic              eng_start_o,
  output logic [31:0]       eng_cmd_o,
  output logic [31:0]       eng_arg_o,
  input  logic              eng_done_i,
  input  logic [127:0]      eng_resp_i,
  input  logic              eng_timeout_i,
  input  logic              eng_crc_bad_i,
  output logic              cmd_inhibit_o,
  output logic              dat_inhibit_o,
  output logic [127:0]      resp_o,
  output logic              cmd_done_o,
  output logic              cmd_err_o,
  output logic              err_timeout_o,
  output logic              err_crc_o,
  output logic              err_index_o,
  output logic              xfer_multi_o,
  output logic              xfer_rd_o,
  output logic              blkcnt_en_o,
  output logic [1:0]        auto_cmd_o,
  output logic [1:0]        cmd_type_o
);
  logic       launch;
  logic       evt;
  err_cause_t cause;

  sd_cmd_launch #(
    .AW     (AW),
    .ARG_OFS(ARG_OFS),
    .CMD_OFS(CMD_OFS)
  ) u_launch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cmd_busy_i(cmd_inhibit_o),
    .cmd_srst_i(cmd_srst_i),
    .launch_o  (launch),
    .start_o   (eng_start_o),
    .cmd_word_o(eng_cmd_o),
    .arg_o     (eng_arg_o)
  );

  // completion only counts while a command is outstanding
  assign evt = eng_done_i && cmd_inhibit_o && !cmd_srst_i;

  sd_cmd_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .has_data_i   (wr_data_i[DATA_BIT]),
    .rsp_i        (rsp_kind_e'(wr_data_i[RSP_LSB +: 2])),
    .evt_i        (evt),
    .cmd_srst_i   (cmd_srst_i),
    .dat_srst_i   (dat_srst_i),
    .cmd_inhibit_o(cmd_inhibit_o),
    .dat_inhibit_o(dat_inhibit_o)
  );

  sd_cmd_resp u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .rsp_i        (rsp_kind_e'(eng_cmd_o[RSP_LSB +: 2])),
    .idx_i        (eng_cmd_o[IDX_LSB +: IDX_W]),
    .idx_chk_i    (eng_cmd_o[IXCHK_BIT]),
    .crc_chk_i    (eng_cmd_o[CRCCHK_BIT]),
    .eng_resp_i   (eng_resp_i),
    .eng_timeout_i(eng_timeout_i),
    .eng_crc_bad_i(eng_crc_bad_i),
    .resp_o       (resp_o),
    .done_o       (cmd_done_o),
    .err_o        (cmd_err_o),
    .cause_o      (cause)
  );

  assign err_timeout_o = cause.tmo;
  assign err_crc_o     = cause.crc;
  assign err_index_o   = cause.idx;

  assign xfer_multi_o = eng_cmd_o[MULTI_BIT];
  assign xfer_rd_o    = eng_cmd_o[DIR_BIT];
  assign blkcnt_en_o  = eng_cmd_o[BCNT_BIT];
  assign auto_cmd_o   = eng_cmd_o[AUTO_LSB +: 2];
  assign cmd_type_o   = eng_cmd_o[TYPE_LSB +: 2];
endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cmd_srst_i,
  input logic         dat_srst_i,
  input logic         eng_start_o,
  input logic         cmd_inhibit_o,
  input logic         dat_inhibit_o,
  input logic [127:0] resp_o,
  input logic         cmd_done_o,
  input logic         cmd_err_o,
  input logic         err_timeout_o,
  input logic         err_crc_o,
  input logic         err_index_o
);
  p_start_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> cmd_inhibit_o);

  p_no_start_when_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> !$past(cmd_inhibit_o));

  p_one_event_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_done_o && cmd_err_o));

  p_event_frees_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_o || cmd_err_o) |-> (!cmd_inhibit_o && $past(cmd_inhibit_o)));

  p_err_has_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> (err_timeout_o || err_crc_o || err_index_o));

  p_cause_needs_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_timeout_o || err_crc_o || err_index_o) |-> cmd_err_o);

  p_timeout_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_timeout_o |-> $stable(resp_o));

  p_cmd_srst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_srst_i |=> (!cmd_inhibit_o && !cmd_done_o && !cmd_err_o));

  p_dat_srst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_srst_i |=> !dat_inhibit_o);
endmodule

bind sd_cmd_issue sd_cmd_issue_chk u_chk (.*);

// File: tb/sd_cmd_issue_tb_top.sv
module sd_cmd_issue_tb_top;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_ARG = 4'd2;
  localparam logic [AW-1:0] A_CMD = 4'd3;
  localparam int WD = 20000;

  typedef struct packed {
    logic [5:0]   idx;
    logic [23:0]  fl;
    logic [127:0] rsp;
    logic         crc_bad;
    logic         tmo;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{6'd0,  24'h100000, 128'h0, 1'b0, 1'b0},
    '{6'd2,  24'h010000, 128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0, 1'b0},
    '{6'd18, 24'h3A0036, 128'h12_A5A51234, 1'b0, 1'b0},
    '{6'd7,  24'h1B0000, 128'h07_00000900, 1'b0, 1'b0},
    '{6'd13, 24'h1A0000, 128'h0D_00000B00, 1'b1, 1'b0},
    '{6'd16, 24'h020000, 128'h10_00000200, 1'b1, 1'b0},
    '{6'd55, 24'h1A0000, 128'h05_00000120, 1'b0, 1'b0},
    '{6'd41, 24'h020000, 128'h3F_80FF8000, 1'b0, 1'b0},
    '{6'd8,  24'h1A0000, 128'h08_DEADBEEF, 1'b0, 1'b1},
    '{6'd12, 24'hDB0000, 128'h0C_00000C00, 1'b0, 1'b0},
    '{6'd24, 24'h3A0000, 128'h18_00000E00, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cmd_srst = 1'b0, dat_srst = 1'b0;
  logic eng_done = 1'b0, eng_tmo = 1'b0, eng_crc = 1'b0;
  logic [127:0] eng_resp = '0;
  logic eng_start, cmd_inh, dat_inh, done, err, e_tmo, e_crc, e_idx;
  logic multi, rd, bcnt;
  logic [1:0] autoc, ctype;
  logic [31:0] eng_cmd, eng_arg;
  logic [127:0] resp;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [127:0] model = '0;

  always #10 clk = ~clk;

  sd_cmd_issue #(.AW(AW), .ARG_OFS(2), .CMD_OFS(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cmd_srst_i(cmd_srst), .dat_srst_i(dat_srst),
    .eng_start_o(eng_start), .eng_cmd_o(eng_cmd), .eng_arg_o(eng_arg),
    .eng_done_i(eng_done), .eng_resp_i(eng_resp), .eng_timeout_i(eng_tmo),
    .eng_crc_bad_i(eng_crc), .cmd_inhibit_o(cmd_inh), .dat_inhibit_o(dat_inh),
    .resp_o(resp), .cmd_done_o(done), .cmd_err_o(err), .err_timeout_o(e_tmo),
    .err_crc_o(e_crc), .err_index_o(e_idx), .xfer_multi_o(multi),
    .xfer_rd_o(rd), .blkcnt_en_o(bcnt), .auto_cmd_o(autoc), .cmd_type_o(ctype)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic engine(input logic [127:0] r, input logic crc, input logic tmo);
    eng_done = 1'b1; eng_resp = r; eng_crc = crc; eng_tmo = tmo;
    tick();
    eng_done = 1'b0; eng_crc = 1'b0; eng_tmo = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    logic [31:0] cmd, arg;
    logic [1:0] kind;
    logic x_idx, x_crc, x_err;
    cmd  = {2'b00, v.idx, v.fl};
    arg  = 32'h4000_0000 + 32'(n);
    kind = cmd[17:16];
    reg_wr(A_ARG, arg);
    reg_wr(A_CMD, cmd);
    chk(eng_start, 1, "R2 start");
    chk(cmd_inh, 1, "R2 cmd inhibit");
    chk(eng_cmd, cmd, "R2 cmd word");
    chk(eng_arg, arg, "R2 argument");
    chk(dat_inh, cmd[21] || kind == 2'd3, "R3 data inhibit");
    chk({multi, rd, bcnt, autoc, ctype}, {cmd[5], cmd[4], cmd[1], cmd[3:2], cmd[23:22]},
        "R12 decoded fields");
    tick();
    chk(eng_start, 0, "R2 start width");
    engine(v.rsp, v.crc_bad, v.tmo);
    x_crc = !v.tmo && cmd[19] && v.crc_bad;
    x_idx = !v.tmo && kind[1] && cmd[20] && (v.rsp[37:32] != v.idx);
    x_err = v.tmo || x_crc || x_idx;
    if (!v.tmo) begin
      if (kind == 2'd1) model = {8'h00, v.rsp[127:8]};
      else if (kind[1]) model[31:0] = v.rsp[31:0];
    end
    chk(cmd_inh, 0, "R5 inhibit cleared");
    chk({done, err}, {!x_err, x_err}, "R5 event");
    chk({e_tmo, e_crc, e_idx}, {v.tmo, x_crc, x_idx}, "R6 cause");
    chk(resp, model, v.tmo ? "R9 kept" : (kind == 2'd1 ? "R7 long" : "R8 short/none"));
    tick();
    chk({done, err}, 2'b00, "R5 pulse width");
    dat_srst = 1'b1;
    tick();
    dat_srst = 1'b0;
    chk(dat_inh, 0, "R11 data reset");
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk({cmd_inh, dat_inh, eng_start, done, err, e_tmo, e_crc, e_idx}, 8'h00, "R1 flags");
    chk(resp, 128'h0, "R1 response");
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) run_vec(VT[i], i);

    // R4: writes during a busy command
    reg_wr(A_ARG, 32'h1111_1111);
    reg_wr(A_CMD, 32'h0302_0000);
    chk(eng_start, 1, "R2 start before busy test");
    reg_wr(A_ARG, 32'h2222_2222);
    reg_wr(A_CMD, 32'h0901_0000);
    chk(eng_start, 0, "R4 no start");
    chk(eng_cmd, 32'h0302_0000, "R4 cmd kept");
    chk(eng_arg, 32'h1111_1111, "R4 arg kept");
    chk(cmd_inh, 1, "R4 still busy");
    // R10: command soft reset, then late completion
    cmd_srst = 1'b1;
    tick();
    cmd_srst = 1'b0;
    chk(cmd_inh, 0, "R10 inhibit cleared");
    engine(128'h03_77777777, 1'b0, 1'b0);
    chk({done, err}, 2'b00, "R10 late done ignored");
    chk(resp, model, "R10 response kept");
    // R2: argument written while busy is used by next launch
    reg_wr(A_CMD, 32'h0302_0000);
    chk(eng_arg, 32'h2222_2222, "R2 last argument");
    // R10: srst wins over completion
    cmd_srst = 1'b1;
    tick();
    cmd_srst = 1'b0;
    chk(cmd_inh, 0, "R10 srst");
    // R10: srst wins over a write in the same cycle
    cmd_srst = 1'b1;
    reg_wr(A_CMD, 32'h0D1A_0000);
    cmd_srst = 1'b0;
    chk({eng_start, cmd_inh}, 2'b00, "R10 write blocked by srst");
    // R11: data reset wins over a data command
    dat_srst = 1'b1;
    reg_wr(A_CMD, 32'h1132_0010);
    dat_srst = 1'b0;
    chk(cmd_inh, 1, "R2 accepted with data reset");
    chk(dat_inh, 0, "R11 reset wins over set");
    engine(128'h11_00000900, 1'b0, 1'b0);
    model[31:0] = 32'h0000_0900;
    chk(done, 1, "R5 done after collision");
    chk(resp, model, "R8 short after collision");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule